// File: doc/BRIEF.md
# Directed Rounding Unit

This block shortens a sign-magnitude significand. The significand arrives with extra low-order bits, and the block removes them to leave a fixed number of kept bits. A two-bit mode input selects the rounding direction. The choices are nearest with ties to even, toward minus infinity, toward plus infinity, and toward zero. The directed modes depend on the sign. For example, rounding toward minus infinity makes the magnitude of a negative value larger.

The block returns the rounded magnitude and passes the sign through unchanged. It also raises a carry-out when the increment overflows the kept width, and an inexact flag when any discarded bit was set. The logic is combinational and feeds an optional output register with a clock enable. The surrounding datapath uses the carry-out to adjust the exponent. That adjustment, normalization and subnormal handling all happen outside this block.

Top module: `drnd_unit`

## Requirements
- R1: In mode 2'b00 (nearest), a discarded part above one half of the kept LSB increments the kept magnitude, and a discarded part below one half leaves it unchanged.
- R2: In mode 2'b00, a discarded part of exactly one half rounds to the neighbour whose kept LSB is 0.
- R3: In mode 2'b01 (toward minus infinity), a nonzero discarded part increments the magnitude of a negative value and truncates a positive one. With 3 fraction bits, +1.0111 gives 1.011 and -1.0111 gives -1.100.
- R4: In mode 2'b10 (toward plus infinity), a nonzero discarded part increments the magnitude of a positive value and truncates a negative one. With 3 fraction bits, +1.0111 gives 1.100 and -1.0111 gives -1.011.
- R5: In mode 2'b11 (toward zero), the discarded bits are always dropped and the carry-out stays 0.
- R6: `inexact_o` is 1 exactly when at least one discarded bit of the input is 1.
- R7: When the increment overflows the kept width (for example 1.111 rounded up), `carry_o` is 1 and `mag_o` is all zeros.
- R8: When every discarded bit is 0, `mag_o` equals the kept input bits, `carry_o` is 0 and `inexact_o` is 0, in all four modes.
- R9: `sign_o` equals the sign of the captured input.
- R10: With the output register present, outputs change one clock edge after capture, and only at edges where `en` is 1. While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output register |
| sign_i | input | 1 | Sign of the operand (1 = negative) |
| mag_i | input | KEEP_W+DROP_W | Operand magnitude; the low DROP_W bits are discarded |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 down, 10 up, 11 toward zero |
| sign_o | output | 1 | Sign of the result |
| mag_o | output | KEEP_W | Rounded magnitude |
| carry_o | output | 1 | Overflow of the kept width caused by rounding |
| inexact_o | output | 1 | At least one discarded bit was 1 |

## Verification
Each output depends only on the current operand, so a fault in the guard, sticky or increment path appears on `mag_o` or `carry_o` one capture edge after the operand that triggers it. A swapped mode decode or sign dependence shows first on operands that have a nonzero discarded part. Tie handling becomes visible only on exact halves, and carry faults only on all-ones kept fields. For these reasons the bench sweeps every operand, sign and mode of a small configuration. It also checks separately that the output holds while `en` is low.

// File: rtl/drnd_pkg.sv
package drnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/drnd_split.sv
// Splits the operand into kept bits, kept LSB, guard, sticky and inexact.
module drnd_split #(
  parameter int KEEP_W = 4,
  parameter int DROP_W = 3,
  localparam int W = KEEP_W + DROP_W
) (
  input  logic [W-1:0]      mag_i,
  output logic [KEEP_W-1:0] kept_o,
  output logic              lsb_o,
  output logic              guard_o,
  output logic              sticky_o,
  output logic              inexact_o
);
  assign kept_o  = mag_i[W-1:DROP_W];
  assign lsb_o   = mag_i[DROP_W];
  assign guard_o = mag_i[DROP_W-1];

  generate
    if (DROP_W > 1) begin : g_sticky
      assign sticky_o = |mag_i[DROP_W-2:0];
    end else begin : g_nosticky
      assign sticky_o = 1'b0;
    end
  endgenerate

  assign inexact_o = guard_o | sticky_o;
endmodule

// File: rtl/drnd_decide.sv
// Decides whether the kept magnitude is incremented.
module drnd_decide
  import drnd_pkg::*;
(
  input  rmode_e mode_i,
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o
);
  logic lost;
  assign lost = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RM_DOWN: inc_o = sign_i & lost;
      RM_UP:   inc_o = ~sign_i & lost;
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/drnd_incr.sv
// Adds the rounding increment and reports overflow of the kept width.
module drnd_incr #(
  parameter int KEEP_W = 4
) (
  input  logic [KEEP_W-1:0] kept_i,
  input  logic              inc_i,
  output logic [KEEP_W-1:0] mag_o,
  output logic              carry_o
);
  logic [KEEP_W:0] sum;
  assign sum     = {1'b0, kept_i} + {{KEEP_W{1'b0}}, inc_i};
  assign mag_o   = sum[KEEP_W-1:0];
  assign carry_o = sum[KEEP_W];
endmodule

// File: rtl/drnd_unit.sv
module drnd_unit
  import drnd_pkg::*;
#(
  parameter int KEEP_W  = 4,
  parameter int DROP_W  = 3,
  parameter bit OUT_REG = 1'b1,
  localparam int W = KEEP_W + DROP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sign_i,
  input  logic [W-1:0]      mag_i,
  input  logic [1:0]        mode_i,
  output logic              sign_o,
  output logic [KEEP_W-1:0] mag_o,
  output logic              carry_o,
  output logic              inexact_o
);
  rmode_e            mode;
  logic [KEEP_W-1:0] kept;
  logic              lsb, guard, sticky, inexact_c, inc;
  logic [KEEP_W-1:0] mag_c;
  logic              carry_c;

  assign mode = rmode_e'(mode_i);

  drnd_split #(.KEEP_W(KEEP_W), .DROP_W(DROP_W)) u_split (
    .mag_i(mag_i), .kept_o(kept), .lsb_o(lsb), .guard_o(guard),
    .sticky_o(sticky), .inexact_o(inexact_c)
  );

  drnd_decide u_decide (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(lsb), .guard_i(guard),
    .sticky_i(sticky), .inc_o(inc)
  );

  drnd_incr #(.KEEP_W(KEEP_W)) u_incr (
    .kept_i(kept), .inc_i(inc), .mag_o(mag_c), .carry_o(carry_c)
  );

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard && !sticky) |-> (!carry_c && mag_c == kept));

  // R7
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_c |-> (mag_c == '0 && kept == '1));

  // R5
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_ZERO) |-> (!carry_c && mag_c == kept));

  // R2
  tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_NEAR && guard && !sticky) |-> !mag_c[0]);

  generate
    if (OUT_REG) begin : g_reg
      logic              sign_q, sign_d;
      logic [KEEP_W-1:0] mag_q, mag_d;
      logic              carry_q, carry_d;
      logic              inx_q, inx_d;

      always_comb begin
        sign_d  = sign_q;
        mag_d   = mag_q;
        carry_d = carry_q;
        inx_d   = inx_q;
        if (en) begin
          sign_d  = sign_i;
          mag_d   = mag_c;
          carry_d = carry_c;
          inx_d   = inexact_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sign_q  <= 1'b0;
          mag_q   <= '0;
          carry_q <= 1'b0;
          inx_q   <= 1'b0;
        end else begin
          sign_q  <= sign_d;
          mag_q   <= mag_d;
          carry_q <= carry_d;
          inx_q   <= inx_d;
        end
      end

      assign sign_o    = sign_q;
      assign mag_o     = mag_q;
      assign carry_o   = carry_q;
      assign inexact_o = inx_q;

      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(mag_o) && $stable(carry_o) && $stable(inexact_o)));

      // R9
      sign_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (sign_o == $past(sign_i)));
    end else begin : g_comb
      assign sign_o    = sign_i;
      assign mag_o     = mag_c;
      assign carry_o   = carry_c;
      assign inexact_o = inexact_c;
    end
  endgenerate
endmodule

// File: tb/tb_drnd_unit.sv
module tb_drnd_unit;
  localparam int K = 4;
  localparam int D = 3;
  localparam int W = K + D;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         sign_i;
  logic [W-1:0] mag_i;
  logic [1:0]   mode_i;
  logic         sign_o;
  logic [K-1:0] mag_o;
  logic         carry_o;
  logic         inexact_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  drnd_unit #(.KEEP_W(K), .DROP_W(D), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sign_i(sign_i), .mag_i(mag_i),
    .mode_i(mode_i), .sign_o(sign_o), .mag_o(mag_o), .carry_o(carry_o),
    .inexact_o(inexact_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference: magnitude m in units of 2^-D of the kept LSB.
  task automatic ref_round(input bit s, input int m, input int md,
                           output int rm, output bit cy, output bit inx);
    int q, rem, half, inc, r;
    q    = m >> D;
    rem  = m % (1 << D);
    half = 1 << (D - 1);
    inc  = 0;
    case (md)
      0: inc = (rem > half || (rem == half && (q % 2) == 1)) ? 1 : 0;
      1: inc = (s && rem != 0) ? 1 : 0;
      2: inc = (!s && rem != 0) ? 1 : 0;
      default: inc = 0;
    endcase
    r   = q + inc;
    cy  = (r >> K) != 0;
    rm  = r % (1 << K);
    inx = rem != 0;
  endtask

  task automatic apply(input bit s, input int m, input int md);
    @(negedge clk);
    sign_i = s;
    mag_i  = m[W-1:0];
    mode_i = md[1:0];
    en     = 1'b1;
    @(negedge clk);
  endtask

  function automatic string mode_tag(input int m, input int md);
    int rem, half;
    rem  = m % (1 << D);
    half = 1 << (D - 1);
    if (rem == 0) return "R8";
    case (md)
      0: return (rem == half) ? "R2" : "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rm;
    bit cy, inx;
    rst_n  = 1'b0;
    en     = 1'b0;
    sign_i = 1'b1;
    mag_i  = '1;
    mode_i = 2'b00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset mag", int'(mag_o), 0);
    chk("R10 reset carry", int'(carry_o), 0);
    chk("R10 reset inexact", int'(inexact_o), 0);
    chk("R10 reset sign", int'(sign_o), 0);
    rst_n = 1'b1;

    // Exhaustive sweep
    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < (1 << W); m++) begin
          apply(s[0], m, md);
          ref_round(s[0], m, md, rm, cy, inx);
          chk({mode_tag(m, md), " mag"}, int'(mag_o), rm);
          chk((m % (1 << D) == 0) ? "R8 carry" : "R7 carry", int'(carry_o), int'(cy));
          chk("R6 inexact", int'(inexact_o), int'(inx));
          chk("R9 sign", int'(sign_o), s);
        end
      end
    end

    // R3 / R4 worked examples: 1.0111 with three kept fraction bits
    apply(1'b0, 7'b1011100, 1); chk("R3 +1.0111 down", int'(mag_o), 4'b1011);
    apply(1'b1, 7'b1011100, 1); chk("R3 -1.0111 down", int'(mag_o), 4'b1100);
    apply(1'b0, 7'b1011100, 2); chk("R4 +1.0111 up", int'(mag_o), 4'b1100);
    apply(1'b1, 7'b1011100, 2); chk("R4 -1.0111 up", int'(mag_o), 4'b1011);
    apply(1'b1, 7'b1011100, 3); chk("R5 -1.0111 zero", int'(mag_o), 4'b1011);
    apply(1'b0, 7'b1010100, 0); chk("R2 tie to even", int'(mag_o), 4'b1010);

    // R7 overflow: 1.111 rounded up
    apply(1'b0, 7'b1111001, 2);
    chk("R7 overflow carry", int'(carry_o), 1);
    chk("R7 overflow mag", int'(mag_o), 0);

    // R10 hold while en is low
    apply(1'b0, 7'b0101011, 0);
    @(negedge clk);
    en     = 1'b0;
    sign_i = 1'b1;
    mag_i  = 7'b1111111;
    mode_i = 2'b01;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold mag", int'(mag_o), 4'b0101);
    chk("R10 hold carry", int'(carry_o), 0);
    chk("R10 hold inexact", int'(inexact_o), 1);
    chk("R10 hold sign", int'(sign_o), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R10 capture after enable", int'(carry_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule